// File: doc/BRIEF.md
# Watchdog Control and Intrusion Status Register

This block is a single 16-bit control and status register that sits beside a system watchdog on a simple register bus. Software uses it to freeze the watchdog counter and to send non-maskable interrupt events to the system-management interrupt line instead. It also holds a set-only lock bit that protects a watchdog-enable bit kept elsewhere. The watchdog counter, the enable bit it protects and the event-message sender sit outside the block. Each of them is reached through a plain port.

The register also latches tamper events from an asynchronous, active-low intrusion input. The input passes through a synchronizer first. The status bit is cleared by writing a one to it. If the input is still active when that write arrives, the clear is held back and takes effect only after the input goes inactive. After a clear is accepted, the bit keeps reading one for a fixed recovery interval. The intrusion state has its own reset, so it survives a core reset. A select code supplied from outside decides whether a latched intrusion requests a system-management interrupt.

Top module: `wdt_ctl_regs`

## Requirements
- R1: Under reset the read value is 0x0000. Bits 15:13, bit 10 and bits 8:1 always read 0, even after a write of 0xFFFF. The field positions are: lock at bit 12, halt at bit 11, NMI routing at bit 9 and intrusion status at bit 0.
- R2: A write with bit 12 set makes the lock bit 1. A later write with bit 12 clear leaves it at 1. Only the core reset `rst_n` returns it to 0.
- R3: `wden_wr_block` equals the lock bit and `wdt_halt` equals bit 11. Bits 11 and 9 take the value written on every bus write.
- R4: `nmi_req` is high exactly when `nmi_evt` is 1, the routing bit is 0 and `nmi_dis` is 0.
- R5: An NMI event drives `smi_req` only when the routing bit is 1, `glb_smi_en` is 1 and `nmi_dis` is 0. No other combination causes an SMI from an NMI.
- R6: Driving `intr_n` low sets the intrusion bit. It reads 1 three clocks after the input changes: two synchronizer stages, then the latch. The bit is kept through a core reset and cleared by `rtc_rst_n`.
- R7: Software clears the intrusion bit by writing 1 to bit 0 while the synchronized input is inactive. The bit keeps reading 1 for REC_CYC clocks after the write edge and reads 0 after that. Writing 0 to bit 0 has no effect on it.
- R8: If the clear is written while the input is active, the set wins and the bit stays 1. The clear is remembered. The recovery interval starts once the synchronized input drops, so the bit reads 0 REC_CYC+3 clocks after `intr_n` returns high.
- R9: A latched intrusion asserts `smi_req` only when `intr_sel` is 2'b10. The codes 2'b00, 2'b01 and 2'b11 never cause an SMI, even when the input drops and asserts again.
- R10: `smi_req` is a level. It stays high for as long as any enabled source condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low |
| rtc_rst_n | input | 1 | Reset for the intrusion state, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read value |
| glb_smi_en | input | 1 | Global SMI enable |
| nmi_dis | input | 1 | NMI disable |
| nmi_evt | input | 1 | NMI event level |
| intr_n | input | 1 | Asynchronous intrusion input, active low |
| intr_sel | input | 2 | Intrusion response select (2'b10 selects SMI) |
| wden_wr_block | output | 1 | Blocks writes to the external watchdog enable |
| wdt_halt | output | 1 | Freezes the watchdog counter |
| smi_req | output | 1 | System-management interrupt request (level) |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
Two things can land in the same clock edge: a software write-one-to-clear of the intrusion bit, and the synchronized intrusion input holding the bit set. The bench provokes this by writing the clear while `intr_n` is held low. It expects the bit and the SMI request to stay high. It then releases the input and expects the bit to read zero exactly REC_CYC+3 clocks later, and not one clock earlier. The NMI routing is swept over all sixteen combinations of its four inputs, and the intrusion select over all four codes, against values computed in the bench.

// File: rtl/wdt_ctl_pkg.sv
package wdt_ctl_pkg;
    localparam int REG_W     = 16;
    localparam int LOCK_BIT  = 12;
    localparam int HALT_BIT  = 11;
    localparam int ROUTE_BIT = 9;
    localparam int INTR_BIT  = 0;

    typedef enum logic [1:0] {
        ISEL_NONE = 2'b00,
        ISEL_IRQ  = 2'b01,
        ISEL_SMI  = 2'b10,
        ISEL_RSVD = 2'b11
    } isel_e;

    typedef struct packed {
        logic lock;
        logic halt;
        logic route;
    } ctl_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_intr_latch.sv
module wdt_intr_latch #(
    parameter int REC_CYC = 8125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_wr,
    output logic det
);
    localparam int CW = $clog2(REC_CYC + 1);

    typedef struct packed {
        logic          det;
        logic          pend;
        logic [CW-1:0] cnt;
    } lst_t;

    lst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) begin
            // set has priority over any clear; remember the clear
            st_d.det  = 1'b1;
            st_d.cnt  = '0;
            st_d.pend = st_q.pend | clr_wr;
        end else if ((clr_wr || st_q.pend) && st_q.det && st_q.cnt == '0) begin
            st_d.cnt  = CW'(REC_CYC);
            st_d.pend = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) st_d.det = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det = st_q.det;
endmodule

// File: rtl/wdt_irq_route.sv
module wdt_irq_route
    import wdt_ctl_pkg::*;
(
    input  logic  nmi_evt,
    input  logic  route,
    input  logic  glb_smi_en,
    input  logic  nmi_dis,
    input  logic  det,
    input  isel_e sel,
    output logic  smi,
    output logic  nmi
);
    logic nmi_smi, intr_smi;

    always_comb begin
        nmi_smi  = nmi_evt && route && glb_smi_en && !nmi_dis;
        intr_smi = det && (sel == ISEL_SMI);
        smi      = nmi_smi || intr_smi;
        nmi      = nmi_evt && !route && !nmi_dis;
    end
endmodule

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
    import wdt_ctl_pkg::*;
#(
    parameter int REC_CYC     = 8125,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_rst_n,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              glb_smi_en,
    input  logic              nmi_dis,
    input  logic              nmi_evt,
    input  logic              intr_n,
    input  logic [1:0]        intr_sel,
    output logic              wden_wr_block,
    output logic              wdt_halt,
    output logic              smi_req,
    output logic              nmi_req
);
    ctl_t ctl_d, ctl_q;
    logic intr_s;
    logic det;
    logic clr_wr;

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr) begin
            ctl_d.lock  = ctl_q.lock | bus_wdata[LOCK_BIT];
            ctl_d.halt  = bus_wdata[HALT_BIT];
            ctl_d.route = bus_wdata[ROUTE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rtc_rst_n),
        .din  (~intr_n),
        .dout (intr_s)
    );

    assign clr_wr = bus_wr && bus_wdata[INTR_BIT];

    wdt_intr_latch #(.REC_CYC(REC_CYC)) u_latch (
        .clk   (clk),
        .rst_n (rtc_rst_n),
        .evt   (intr_s),
        .clr_wr(clr_wr),
        .det   (det)
    );

    wdt_irq_route u_route (
        .nmi_evt   (nmi_evt),
        .route     (ctl_q.route),
        .glb_smi_en(glb_smi_en),
        .nmi_dis   (nmi_dis),
        .det       (det),
        .sel       (isel_e'(intr_sel)),
        .smi       (smi_req),
        .nmi       (nmi_req)
    );

    always_comb begin
        bus_rdata            = '0;
        bus_rdata[LOCK_BIT]  = ctl_q.lock;
        bus_rdata[HALT_BIT]  = ctl_q.halt;
        bus_rdata[ROUTE_BIT] = ctl_q.route;
        bus_rdata[INTR_BIT]  = det;
    end

    assign wden_wr_block = ctl_q.lock;
    assign wdt_halt      = ctl_q.halt;
endmodule

// File: rtl/wdt_ctl_regs_chk.sv
module wdt_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rtc_rst_n,
    input logic [15:0] bus_rdata,
    input logic        glb_smi_en,
    input logic        nmi_dis,
    input logic        nmi_evt,
    input logic [1:0]  intr_sel,
    input logic        wden_wr_block,
    input logic        wdt_halt,
    input logic        smi_req,
    input logic        nmi_req,
    input logic        intr_s
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        bus_rdata[15:13] == 3'b000 && !bus_rdata[10] && bus_rdata[8:1] == 8'h00);

    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        wden_wr_block |=> wden_wr_block);

    a_r3_flags_track: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        wden_wr_block == bus_rdata[12] && wdt_halt == bus_rdata[11]);

    a_r4_routed_nmi_blocked: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        (bus_rdata[9] || nmi_dis) |-> !nmi_req);

    a_r5_no_stray_smi: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        (!bus_rdata[0] && !(nmi_evt && bus_rdata[9] && glb_smi_en && !nmi_dis)) |-> !smi_req);

    a_r8_no_drop_while_active: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        $fell(bus_rdata[0]) |-> !$past(intr_s));

    a_r9_sel_gates_smi: assert property (@(posedge clk) disable iff (!rst_n || !rtc_rst_n)
        (bus_rdata[0] && intr_sel == 2'b10) |-> smi_req);
endmodule

bind wdt_ctl_regs wdt_ctl_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_rst_n    (rtc_rst_n),
    .bus_rdata    (bus_rdata),
    .glb_smi_en   (glb_smi_en),
    .nmi_dis      (nmi_dis),
    .nmi_evt      (nmi_evt),
    .intr_sel     (intr_sel),
    .wden_wr_block(wden_wr_block),
    .wdt_halt     (wdt_halt),
    .smi_req      (smi_req),
    .nmi_req      (nmi_req),
    .intr_s       (intr_s)
);

// File: tb/tb_wdt_ctl_regs.sv
module tb_wdt_ctl_regs;
    localparam int REC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        glb_smi_en = 1'b0;
    logic        nmi_dis = 1'b0;
    logic        nmi_evt = 1'b0;
    logic        intr_n = 1'b1;
    logic [1:0]  intr_sel = 2'b00;
    logic        wden_wr_block, wdt_halt, smi_req, nmi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_ctl_regs #(.REC_CYC(REC), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glb_smi_en(glb_smi_en), .nmi_dis(nmi_dis), .nmi_evt(nmi_evt),
        .intr_n(intr_n), .intr_sel(intr_sel),
        .wden_wr_block(wden_wr_block), .wdt_halt(wdt_halt),
        .smi_req(smi_req), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [15:0] d);
        bus_wr = 1'b1;
        bus_wdata = d;
        tick();
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(2);
        chk("R1 reset value", bus_rdata, 16'h0000);
        rst_n = 1'b1;
        rtc_rst_n = 1'b1;
        tick();

        // R1: reserved bits read zero after writing all ones
        wr(16'hFFFE);
        chk("R1 reserved after 0xFFFE", bus_rdata, 16'h1A00);
        // R3 flag outputs
        chk("R3 write block", {15'd0, wden_wr_block}, 16'd1);
        chk("R3 halt", {15'd0, wdt_halt}, 16'd1);
        // R2: zero write keeps lock, clears halt and routing
        wr(16'h0000);
        chk("R2 lock survives zero write", bus_rdata, 16'h1000);
        chk("R3 halt cleared", {15'd0, wdt_halt}, 16'd0);
        wr(16'h0800);
        chk("R3 halt set alone", bus_rdata, 16'h1800);
        // R2: only core reset clears lock
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R2 core reset clears lock", bus_rdata, 16'h0000);

        // R4 / R5: exhaustive sweep of NMI routing
        for (int v = 0; v < 16; v++) begin
            logic ev, rt, ge, nd;
            {ev, rt, ge, nd} = 4'(v);
            wr(rt ? 16'h0200 : 16'h0000);
            nmi_evt = ev;
            glb_smi_en = ge;
            nmi_dis = nd;
            #1;
            chk("R5 nmi to smi", {15'd0, smi_req}, {15'd0, ev & rt & ge & ~nd});
            chk("R4 nmi pass", {15'd0, nmi_req}, {15'd0, ev & ~rt & ~nd});
        end
        nmi_evt = 1'b0;
        glb_smi_en = 1'b0;
        nmi_dis = 1'b0;
        wr(16'h0000);

        // R6: intrusion set latency
        intr_n = 1'b0;
        tick(2);
        chk("R6 not yet latched", {15'd0, bus_rdata[0]}, 16'd0);
        tick();
        chk("R6 latched", {15'd0, bus_rdata[0]}, 16'd1);

        // R9 / R10: select sweep, level SMI held
        for (int s = 0; s < 4; s++) begin
            intr_sel = 2'(s);
            tick(2);
            chk("R9 sel code", {15'd0, smi_req}, {15'd0, s == 2});
        end
        intr_sel = 2'b10;

        // R8: clear while active, set wins
        wr(16'h0001);
        chk("R8 set wins", {15'd0, bus_rdata[0]}, 16'd1);
        chk("R10 smi stays high", {15'd0, smi_req}, 16'd1);
        tick(3);
        chk("R8 held while active", {15'd0, bus_rdata[0]}, 16'd1);
        intr_n = 1'b1;
        tick(REC + 2);
        chk("R8 recovery not elapsed", {15'd0, bus_rdata[0]}, 16'd1);
        tick();
        chk("R8 deferred clear done", {15'd0, bus_rdata[0]}, 16'd0);
        chk("R10 smi drops", {15'd0, smi_req}, 16'd0);

        // R6: core reset keeps intrusion, rtc reset clears
        intr_n = 1'b0;
        tick(3);
        intr_n = 1'b1;
        tick(3);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R6 survives core reset", {15'd0, bus_rdata[0]}, 16'd1);

        // R7: zero write no effect, immediate clear with recovery
        wr(16'h0000);
        chk("R7 zero write ignored", {15'd0, bus_rdata[0]}, 16'd1);
        wr(16'h0001);
        tick(REC - 1);
        chk("R7 recovery window", {15'd0, bus_rdata[0]}, 16'd1);
        tick();
        chk("R7 cleared", {15'd0, bus_rdata[0]}, 16'd0);

        // R9: no SMI with none-select even on reassert
        intr_sel = 2'b00;
        intr_n = 1'b0;
        tick(3);
        intr_n = 1'b1;
        tick();
        intr_n = 1'b0;
        tick(3);
        chk("R9 reassert no smi", {15'd0, smi_req}, 16'd0);
        chk("R9 bit still latched", {15'd0, bus_rdata[0]}, 16'd1);
        intr_n = 1'b1;
        tick(3);
        rtc_rst_n = 1'b0;
        tick();
        rtc_rst_n = 1'b1;
        tick();
        chk("R6 rtc reset clears", {15'd0, bus_rdata[0]}, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule